// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects interrupt events from eleven leaf groups and folds them into one interrupt line through a second, master level. The leaf groups are four engine groups, three display-pipe groups, a port group, a misc group, a south-side group and a power-unit group. Each leaf group has four 32-bit registers:

- **status** returns the raw event inputs.
- **mask** drops events whose mask bit is set.
- **identity** latches events that were not masked. Software clears it by writing 1 to a bit.
- **enable** selects which latched bits reach the master level.

The master register holds a set of read-only summary bits. Each summary bit follows the OR of (identity AND enable) over one leaf group, or over one 16-bit half of a leaf group. Master bit 31 is the only bit software can write, and it acts as the global enable for the single registered interrupt output.

Software reaches every register through one word-wide register port. The write strobe is single-cycle and the read data is combinational. The event inputs form one flat vector of single-cycle pulses, 32 bits per group. Every identity, enable and master-enable update takes effect at the clock edge that applies it. The interrupt output is registered at that same edge, so it already reflects the new state one clock after the write or event.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Register addresses are byte addresses, and only word-aligned addresses decode.
  - Group g (0 to 10) starts at g*0x10. Its status register is at +0x0, mask at +0x4, identity at +0x8 and enable at +0xC.
  - The master register is at 0x100.
  - Group index order: engine 0 to 3 are 0 to 3, pipes A, B and C are 4 to 6, port is 7, misc is 8, south is 9 and power is 10.
  - Event input bit b of group g is `evt_in[g*32+b]`.
- R2: An event bit with mask bit 0 sets the matching identity bit at the next clock edge. An event bit with mask bit 1 is dropped and never latched.
- R3: A write to an identity register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event arrives in the same cycle as a write-1-to-clear of the same identity bit, the bit stays set.
- R5: Mask and enable registers store the written value as is, and read back that value.
- R6: Each master summary bit reads 1 exactly when (identity AND enable) of its source is non-zero within the mapped range, and 0 otherwise:
  - bit 0 from engine 0 bits [15:0], and bit 1 from engine 0 bits [31:16]
  - bits 2 and 3 from engine 1 bits [15:0] and [31:16]
  - bit 4 from engine 2 bits [15:0], and bit 6 from engine 3 bits [15:0]
  - bits 16, 17 and 18 from all 32 bits of pipes A, B and C
  - bit 20 from the port group, bit 22 from the misc group, bit 23 from the south group and bit 30 from the power group
  - all other bits below 31 read 0
- R7: In the master register only bit 31 is writable, and it reads back as written. Writes never change the summary bits.
- R8: `irq_o` is 1 exactly when master bit 31 is 1 and some master summary bit is 1. It is registered, and it reflects the state produced by the same clock edge that applied the write or event.
- R9: A status read returns the current `evt_in` bits of that group. Reads of unmapped addresses return 0, and writes to them change no register.
- R10: Synchronous active-high reset sets every mask register to all ones and clears every identity register, every enable register, master bit 31 and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_in | input | 352 | Event pulses, 32 bits per group, group g at [g*32 +: 32] |
| irq_o | output | 1 | Registered interrupt output |

## Verification
Every group is swept with a single event at bit positions 0, 5, 15, 16, 24 and 31. This separates the low-half summaries from the high-half summaries, and exposes that the upper halves of engine groups 2 and 3 never reach the master. Each latched bit is then cleared again, which shows that the summary is level-tracked and not sticky.

Separate patterns cover the following:
- events held while masked, which must not latch but must show in status;
- an identity bit set while its enable is 0, to show the enable gates the summary;
- a clear racing an event, where the event must win;
- master writes of all ones and all zeros, to show that only bit 31 is writable and that it gates `irq_o`;
- reads and writes at unmapped addresses.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int DW      = 32;
  localparam int NGRP    = 11;
  localparam int GW      = 4;
  localparam int ADDR_W  = 9;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = 9'h100;

  // register selector inside one group
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_IDENT  = 2'd2,
    SEL_ENABLE = 2'd3
  } leaf_sel_e;

  typedef struct packed {
    logic            grp_hit;
    logic            mst_hit;
    logic [GW-1:0]   grp;
    leaf_sel_e       sel;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.grp     = a[7:4];
    d.sel     = leaf_sel_e'(a[3:2]);
    d.grp_hit = (a[8] == 1'b0) && (a[1:0] == 2'b00) && (int'(a[7:4]) < NGRP);
    d.mst_hit = (a == MASTER_ADDR);
    return d;
  endfunction

  // fold per-group pending vectors into master summary bits (bit 31 excluded)
  function automatic logic [DW-1:0] fold_summary(input logic [NGRP*DW-1:0] p);
    logic [DW-1:0] s;
    s     = '0;
    s[0]  = |p[0*DW      +: 16];
    s[1]  = |p[0*DW + 16 +: 16];
    s[2]  = |p[1*DW      +: 16];
    s[3]  = |p[1*DW + 16 +: 16];
    s[4]  = |p[2*DW      +: 16];
    s[6]  = |p[3*DW      +: 16];
    s[16] = |p[4*DW      +: DW];
    s[17] = |p[5*DW      +: DW];
    s[18] = |p[6*DW      +: DW];
    s[20] = |p[7*DW      +: DW];
    s[22] = |p[8*DW      +: DW];
    s[23] = |p[9*DW      +: DW];
    s[30] = |p[10*DW     +: DW];
    return s;
  endfunction
endpackage

// File: rtl/cirq_leaf.sv
module cirq_leaf
  import cirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt,
  input  logic          wr_mask,
  input  logic          wr_ident,
  input  logic          wr_enable,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] ident_q,
  output logic [DW-1:0] enable_q,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] pend_nx
);
  logic [DW-1:0] arm_hits;   // events that pass the mask this cycle
  logic [DW-1:0] clr_bits;   // bits software asks to clear this cycle
  logic [DW-1:0] ident_nx, mask_nx, enable_nx;

  always_comb begin
    arm_hits  = evt & ~mask_q;
    clr_bits  = wr_ident ? wdata : '0;
    ident_nx  = (ident_q & ~clr_bits) | arm_hits;
    mask_nx   = wr_mask   ? wdata : mask_q;
    enable_nx = wr_enable ? wdata : enable_q;
    pend_q    = ident_q & enable_q;
    pend_nx   = ident_nx & enable_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      ident_q  <= '0;
      enable_q <= '0;
    end else begin
      mask_q   <= mask_nx;
      ident_q  <= ident_nx;
      enable_q <= enable_nx;
    end
  end

  // R2: a bit newly set in identity must have been unmasked
  p_masked_drop_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ident_q & ~$past(ident_q) & $past(mask_q)) == '0));

  // R4: an unmasked event always lands, even against a clear
  p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (arm_hits != '0) |=> ((ident_q & $past(arm_hits)) == $past(arm_hits)));

  // R3: written ones without a racing event are gone after the write
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    wr_ident |=> ((ident_q & $past(wdata & ~arm_hits)) == '0));

  // R5: mask write stored as written
  p_mask_store_r5: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/cirq_master.sv
module cirq_master
  import cirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NGRP*DW-1:0] pend_q,
  input  logic [NGRP*DW-1:0] pend_nx,
  input  logic               wr_master,
  input  logic               wbit_en,
  output logic [DW-1:0]      master_rd,
  output logic               irq_o
);
  logic          en_q, en_nx;
  logic [DW-1:0] summ_q, summ_nx;
  logic          any_q, irq_nx;

  always_comb begin
    en_nx     = wr_master ? wbit_en : en_q;
    summ_q    = fold_summary(pend_q);
    summ_nx   = fold_summary(pend_nx);
    any_q     = |summ_q[DW-2:0];
    irq_nx    = en_nx & (|summ_nx[DW-2:0]);
    master_rd = {en_q, summ_q[DW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      en_q  <= en_nx;
      irq_o <= irq_nx;
    end
  end

  // R8: the line is never up while the global enable is off
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> en_q);

  // R8: registered line agrees with current enable and summary
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (en_q && any_q)));

  // R7: master enable takes the written bit
  p_en_store_r7: assert property (@(posedge clk) disable iff (rst)
    wr_master |=> (en_q == $past(wbit_en)));
endmodule

// File: rtl/cirq_regmux.sv
module cirq_regmux
  import cirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NGRP*DW-1:0] evt_all,
  input  logic [NGRP*DW-1:0] mask_all,
  input  logic [NGRP*DW-1:0] ident_all,
  input  logic [NGRP*DW-1:0] enable_all,
  input  logic [DW-1:0]      master_rd,
  output logic [NGRP-1:0]    wr_mask,
  output logic [NGRP-1:0]    wr_ident,
  output logic [NGRP-1:0]    wr_enable,
  output logic               wr_master,
  output logic [DW-1:0]      reg_rdata
);
  dec_t dec;

  always_comb begin
    dec       = decode_addr(reg_addr);
    wr_master = reg_wr & dec.mst_hit;
    for (int g = 0; g < NGRP; g++) begin
      wr_mask[g]   = reg_wr & dec.grp_hit & (int'(dec.grp) == g) & (dec.sel == SEL_MASK);
      wr_ident[g]  = reg_wr & dec.grp_hit & (int'(dec.grp) == g) & (dec.sel == SEL_IDENT);
      wr_enable[g] = reg_wr & dec.grp_hit & (int'(dec.grp) == g) & (dec.sel == SEL_ENABLE);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (dec.mst_hit) begin
      reg_rdata = master_rd;
    end else if (dec.grp_hit) begin
      case (dec.sel)
        SEL_STATUS: reg_rdata = evt_all[int'(dec.grp)*DW +: DW];
        SEL_MASK:   reg_rdata = mask_all[int'(dec.grp)*DW +: DW];
        SEL_IDENT:  reg_rdata = ident_all[int'(dec.grp)*DW +: DW];
        default:    reg_rdata = enable_all[int'(dec.grp)*DW +: DW];
      endcase
    end
  end

  // R1: at most one register write strobe per cycle
  p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_mask, wr_ident, wr_enable, wr_master}));

  // R9: no strobe without a decoded hit
  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !dec.grp_hit && !dec.mst_hit) |->
      ({wr_mask, wr_ident, wr_enable, wr_master} == '0));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NGRP*DW-1:0] evt_in,
  output logic               irq_o
);
  logic [NGRP-1:0]    wr_mask, wr_ident, wr_enable;
  logic               wr_master;
  logic [NGRP*DW-1:0] mask_all, ident_all, enable_all, pend_q_all, pend_nx_all;
  logic [DW-1:0]      master_rd;

  cirq_regmux u_mux (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .evt_all(evt_in), .mask_all(mask_all), .ident_all(ident_all),
    .enable_all(enable_all), .master_rd(master_rd),
    .wr_mask(wr_mask), .wr_ident(wr_ident), .wr_enable(wr_enable),
    .wr_master(wr_master), .reg_rdata(reg_rdata)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_leaf
    cirq_leaf u_leaf (
      .clk(clk), .rst(rst),
      .evt(evt_in[g*DW +: DW]),
      .wr_mask(wr_mask[g]), .wr_ident(wr_ident[g]), .wr_enable(wr_enable[g]),
      .wdata(reg_wdata),
      .mask_q(mask_all[g*DW +: DW]),
      .ident_q(ident_all[g*DW +: DW]),
      .enable_q(enable_all[g*DW +: DW]),
      .pend_q(pend_q_all[g*DW +: DW]),
      .pend_nx(pend_nx_all[g*DW +: DW])
    );
  end

  cirq_master u_mst (
    .clk(clk), .rst(rst), .pend_q(pend_q_all), .pend_nx(pend_nx_all),
    .wr_master(wr_master), .wbit_en(reg_wdata[DW-1]),
    .master_rd(master_rd), .irq_o(irq_o)
  );
endmodule

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [8:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [NG*32-1:0] evt_in = '0;
  logic         irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_ident [NG];
  logic [31:0] m_en [NG];
  logic        m_men;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_o(irq_o)
  );

  function automatic logic [8:0] ga(input int g, input int off);
    return 9'(g * 16 + off);
  endfunction

  // bench-side summary: per group, take halves, then place
  function automatic logic [31:0] exp_summary();
    logic [31:0] s = '0;
    for (int g = 0; g < NG; g++) begin
      logic [31:0] p = m_ident[g] & m_en[g];
      logic lo = (p[15:0] != 0);
      logic hi = (p[31:16] != 0);
      case (g)
        0: begin s[0] = lo; s[1] = hi; end
        1: begin s[2] = lo; s[3] = hi; end
        2: s[4] = lo;
        3: s[6] = lo;
        4, 5, 6: s[12 + g] = lo | hi;
        7: s[20] = lo | hi;
        8: s[22] = lo | hi;
        9: s[23] = lo | hi;
        default: s[30] = lo | hi;
      endcase
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int g, input int b);
    @(negedge clk);
    evt_in = '0;
    evt_in[g*32 + b] = 1'b1;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic chk_master(input string req);
    logic [31:0] v;
    logic [31:0] s;
    s = exp_summary();
    rd(9'h100, v);
    chk(req, v, {m_men, s[30:0]});
    chk({req, " irq"}, {31'd0, irq_o}, {31'd0, m_men & (s[30:0] != 0)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bits [6] = '{0, 5, 15, 16, 24, 31};
    for (int g = 0; g < NG; g++) begin m_ident[g] = '0; m_en[g] = '0; end
    m_men = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    for (int g = 0; g < NG; g++) begin
      rd(ga(g, 4), v);  chk("R10 mask reset", v, 32'hFFFF_FFFF);
      rd(ga(g, 8), v);  chk("R10 ident reset", v, 32'h0);
      rd(ga(g, 12), v); chk("R10 enable reset", v, 32'h0);
    end
    rd(9'h100, v); chk("R10 master reset", v, 32'h0);
    chk("R10 irq reset", {31'd0, irq_o}, 32'h0);

    // R9 status shows raw level; R2 masked events not latched
    @(negedge clk);
    evt_in[5*32 +: 32] = 32'hA5A5_0F0F;
    rd(ga(5, 0), v); chk("R9 status raw", v, 32'hA5A5_0F0F);
    repeat (3) @(negedge clk);
    evt_in = '0;
    rd(ga(5, 8), v); chk("R2 masked dropped", v, 32'h0);
    rd(ga(5, 0), v); chk("R9 status follows", v, 32'h0);

    // R1 / R5 distinct per-group readback
    for (int g = 0; g < NG; g++) wr(ga(g, 12), 32'h1000_0000 | 32'(g * 3 + 1));
    for (int g = 0; g < NG; g++) begin
      rd(ga(g, 12), v); chk("R1 R5 enable readback", v, 32'h1000_0000 | 32'(g * 3 + 1));
      m_en[g] = 32'h1000_0000 | 32'(g * 3 + 1);
    end
    wr(ga(3, 4), 32'h1234_5678);
    rd(ga(3, 4), v); chk("R5 mask readback", v, 32'h1234_5678);

    // R7 only bit 31 writable
    wr(9'h100, 32'hFFFF_FFFF); m_men = 1'b1;
    rd(9'h100, v); chk("R7 master write", v, 32'h8000_0000);

    // open masks, enable everything
    for (int g = 0; g < NG; g++) begin
      wr(ga(g, 4), 32'h0);
      wr(ga(g, 12), 32'hFFFF_FFFF); m_en[g] = '1;
    end

    // R2 R3 R6 R8 sweep over groups and bit positions
    for (int g = 0; g < NG; g++) begin
      for (int k = 0; k < 6; k++) begin
        pulse(g, bits[k]);
        m_ident[g] = 32'h1 << bits[k];
        rd(ga(g, 8), v); chk("R2 ident set", v, m_ident[g]);
        chk_master("R6 R8 summary");
        wr(ga(g, 8), 32'h1 << bits[k]);
        m_ident[g] = '0;
        rd(ga(g, 8), v); chk("R3 cleared", v, 32'h0);
        chk_master("R6 level clear");
      end
    end

    // R3 zero bits untouched
    pulse(7, 3); pulse(7, 9);
    wr(ga(7, 8), 32'h0000_0008);
    rd(ga(7, 8), v); chk("R3 partial clear", v, 32'h0000_0200);
    m_ident[7] = 32'h0000_0200;

    // R6 enable gating re-evaluated on enable write
    wr(ga(7, 12), 32'h0); m_en[7] = '0;
    chk_master("R6 enable off");
    wr(ga(7, 12), 32'h0000_0200); m_en[7] = 32'h0000_0200;
    chk_master("R6 enable on");

    // R7 summary not writable by zero write; R8 gate off
    wr(9'h100, 32'h0); m_men = 1'b0;
    chk_master("R7 R8 gate off");
    chk("R8 irq low when disabled", {31'd0, irq_o}, 32'h0);
    wr(9'h100, 32'h8000_0000); m_men = 1'b1;
    chk("R8 irq high when enabled", {31'd0, irq_o}, 32'h1);

    // R4 event wins over same-cycle clear; other bit still clears
    pulse(0, 8);
    m_ident[0] = 32'h0000_0100;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ga(0, 8); reg_wdata = 32'h0000_0180;
    evt_in[0*32 + 7] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    m_ident[0] = 32'h0000_0080;
    rd(ga(0, 8), v); chk("R4 event wins", v, 32'h0000_0080);
    chk_master("R4 summary");

    // R9 unmapped reads and writes
    rd(9'h0C0, v); chk("R9 unmapped read", v, 32'h0);
    rd(9'h104, v); chk("R9 unmapped read hi", v, 32'h0);
    wr(9'h0B8, 32'hFFFF_FFFF);
    wr(9'h10A, 32'h0);
    wr(9'h00A, 32'hFFFF_FFFF);
    rd(ga(10, 4), v); chk("R9 write ignored mask", v, 32'h0);
    rd(ga(0, 8), v);  chk("R9 write ignored ident", v, 32'h0000_0080);
    chk_master("R9 master untouched");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule